// File: doc/BRIEF.md
# Byte-Stream Frame Aligner with Out-of-Frame and Loss-of-Frame Alarms

This block takes a received SDH signal that is already byte-aligned and presented one byte per enabled clock. It looks for the framing pattern at the boundary between the A1 and A2 bytes. Once it has seen the pattern at a stable position, it locks a row/column timing counter to that position. Every byte it passes on is tagged with its row and column, and a pulse marks the first byte of each frame while the block is in frame. The aligned bytes are handed unchanged to the descrambler that follows. The framing bytes themselves are never scrambled, so matching happens on the raw stream.

Four threshold inputs, counted in frames, control the alarms:
- how many consecutive frames must show the pattern before in-frame is declared;
- how many consecutive misses put the block out of frame;
- how long out-of-frame must last before loss-of-frame is raised;
- how long in-frame must last before loss-of-frame is cleared.

A mode input selects the frame length. STM-1 has 270 columns and STM-0 has 90 columns, both with nine rows. The mode is expected to change only while reset is held.

Top module: `frame_aligner`

## Requirements
- R1: While rst_n is low at a clock edge, the block resets to out-of-frame. After that edge, oof is 1, lof is 0, al_valid is 0 and frame_start is 0.
- R2: The framing pattern differs by mode.
  - With mode_stm1=1, the pattern is the byte sequence F6h, 28h, 28h, and its last byte is at row 0, column 4.
  - With mode_stm1=0, the pattern is F6h, 28h, and its last byte is at row 0, column 1.
  - A match while hunting realigns the timing counter, so that the matching byte takes that position.
- R3: In-frame (oof low) is declared after the pattern has been found at the expected position in thr_lock consecutive frames. The frame of the first match counts as one of these. A threshold of 0 acts as 1.
- R4: The timing counter runs over columns 0 to 269 (mode_stm1=1) or 0 to 89 (mode_stm1=0), and rows 0 to 8. al_row and al_col give the position of the byte on al_byte. While in frame, a pattern anywhere other than the expected position does not move the counter.
- R5: While in frame, oof rises after thr_miss consecutive frames in which the byte at the expected position does not complete the pattern. A frame that matches restarts this count.
- R6: lof rises at the end of the thr_lof_set-th frame that ends entirely out of frame (threshold 0 acts as 1).
- R7: Once lof is set, it falls at the end of the thr_lof_clr-th frame that ends entirely in frame (threshold 0 acts as 1).
- R8: al_byte equals rx_byte, and al_valid equals rx_en, one clock later. A cycle with rx_en low moves neither the timing counter nor the pattern history.
- R9: frame_start is 1 together with the byte at row 0, column 0, only if the block was in frame when that byte arrived.
- R10: After a one-byte slip of the incoming stream, oof rises on the thr_miss-th misaligned frame. The block then relocks to the new position and reports positions consistent with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Byte enable for rx_byte |
| rx_byte | input | 8 | Received byte, byte-aligned, not descrambled |
| mode_stm1 | input | 1 | 1: 270-column frame, 0: 90-column frame |
| thr_lock | input | THR_W | Consecutive matching frames needed to declare in-frame |
| thr_miss | input | THR_W | Consecutive missed frames needed to declare out-of-frame |
| thr_lof_set | input | THR_W | Out-of-frame frames needed to raise loss-of-frame |
| thr_lof_clr | input | THR_W | In-frame frames needed to clear loss-of-frame |
| al_byte | output | 8 | Aligned byte toward the descrambler |
| al_valid | output | 1 | al_byte holds a new byte |
| al_row | output | ROW_W | Row of al_byte |
| al_col | output | COL_W | Column of al_byte |
| frame_start | output | 1 | First byte of a frame while in frame |
| oof | output | 1 | Out-of-frame alarm |
| lof | output | 1 | Loss-of-frame alarm |

## Verification
Some properties are checked by assertions on every cycle:
- the counter stays inside the frame for the selected mode;
- the counter and the pattern history freeze on idle cycles;
- a realignment lands on the pattern position;
- in-frame is only ever entered on a match;
- out-of-frame is only entered on a miss at the check position;
- loss-of-frame only changes at a frame end and in the matching alarm state.

Other behaviour can only be shown by the bench scenarios, which compare every output byte and position against a scoreboard:
- the exact number of frames before each alarm changes;
- the restart of the miss count by a good frame;
- the decoy patterns being ignored in frame;
- the relock after a slip;
- the zero-threshold case.

// File: rtl/fa_pkg.sv
// Shared constants and types for the frame aligner.
// Assumes the pattern bytes are compared before descrambling.
package fa_pkg;
    localparam logic [7:0] FA_A1      = 8'hF6;
    localparam logic [7:0] FA_A2      = 8'h28;
    localparam int         FA_ROWS    = 9;
    localparam int         FA_CHK_HI  = 4;   // column of the last pattern byte, 270-column frame
    localparam int         FA_CHK_LO  = 1;   // column of the last pattern byte, 90-column frame

    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_PRESYNC = 2'd1,
        ST_SYNC    = 2'd2
    } fa_state_e;
endpackage

// File: rtl/fa_pattern_det.sv
// Framing pattern detector.
// It keeps the two previous enabled bytes and flags the byte that completes
// F6 28 28 (mode_hi=1) or F6 28 (mode_hi=0).
// It assumes a byte-aligned input; history advances only on enabled bytes.
module fa_pattern_det
    import fa_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          mode_hi,
    input  logic [DW-1:0] din,
    output logic          match
);
    localparam int HIST = 2;

    logic [DW-1:0] hist_q [HIST];

    // Shift the byte history on each enabled byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < HIST; i++) hist_q[i] <= '0;
        end else if (en) begin
            hist_q[0] <= din;
            for (int i = 1; i < HIST; i++) hist_q[i] <= hist_q[i-1];
        end
    end

    // Compare the current byte and history against the mode's pattern.
    always_comb begin
        if (mode_hi)
            match = en && (din == FA_A2) && (hist_q[0] == FA_A2) && (hist_q[1] == FA_A1);
        else
            match = en && (din == FA_A2) && (hist_q[0] == FA_A1);
    end

    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(hist_q[0]) && $stable(hist_q[1]))); // R8
endmodule

// File: rtl/fa_timing.sv
// Row/column timing counter.
// cur_row/cur_col give the position of the byte now at the input.
// A load places that byte at the pattern check position.
// The counter free-runs otherwise, advancing on enabled bytes only.
// The mode must be static outside reset.
module fa_timing
    import fa_pkg::*;
#(
    parameter int COLS_HI = 270,
    parameter int COLS_LO = 90,
    parameter int ROW_W   = 4,
    parameter int COL_W   = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             mode_hi,
    input  logic             load,
    output logic [ROW_W-1:0] cur_row,
    output logic [COL_W-1:0] cur_col,
    output logic             at_check,
    output logic             frame_end
);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(FA_ROWS - 1);
    localparam logic [COL_W-1:0] LAST_HI  = COL_W'(COLS_HI - 1);
    localparam logic [COL_W-1:0] LAST_LO  = COL_W'(COLS_LO - 1);
    localparam logic [COL_W-1:0] CHK_HI   = COL_W'(FA_CHK_HI);
    localparam logic [COL_W-1:0] CHK_LO   = COL_W'(FA_CHK_LO);

    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic [COL_W-1:0] col_last;
    logic [COL_W-1:0] chk_col;

    // Pick the mode's frame width and check column.
    always_comb begin
        col_last = mode_hi ? LAST_HI : LAST_LO;
        chk_col  = mode_hi ? CHK_HI  : CHK_LO;
    end

    // Position of the present byte, overridden by a realignment.
    always_comb begin
        cur_row   = load ? '0 : row_q;
        cur_col   = load ? chk_col : col_q;
        at_check  = (row_q == '0) && (col_q == chk_col);
        frame_end = en && (cur_row == ROW_LAST) && (cur_col == col_last);
    end

    // Advance the counter past the present byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            col_q <= '0;
        end else if (en) begin
            if (cur_col >= col_last) begin
                col_q <= '0;
                row_q <= (cur_row >= ROW_LAST) ? '0 : cur_row + 1'b1;
            end else begin
                col_q <= cur_col + 1'b1;
                row_q <= cur_row;
            end
        end
    end

    AST_COL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        col_q <= col_last); // R4
    AST_ROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        row_q <= ROW_LAST); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(row_q) && $stable(col_q))); // R8
    AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (load && en) |=> (row_q == '0 && col_q == chk_col + 1'b1)); // R2
endmodule

// File: rtl/fa_sync_fsm.sv
// Hunt / presync / sync state machine.
// In hunt it realigns on any match.
// In presync and sync it looks only at the check position.
// Zero thresholds are treated as one.
module fa_sync_fsm
    import fa_pkg::*;
#(
    parameter int THR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             match,
    input  logic             at_check,
    input  logic [THR_W-1:0] thr_lock,
    input  logic [THR_W-1:0] thr_miss,
    output logic             load,
    output logic             oof
);
    fa_state_e      state_q;
    logic [THR_W-1:0] hits_q;
    logic [THR_W-1:0] miss_q;
    logic [THR_W:0]   lock_eff;
    logic [THR_W:0]   miss_eff;
    logic [THR_W:0]   hits_nxt;
    logic [THR_W:0]   miss_nxt;

    // Clamp thresholds and form the next counts.
    always_comb begin
        lock_eff = (thr_lock == '0) ? (THR_W+1)'(1) : {1'b0, thr_lock};
        miss_eff = (thr_miss == '0) ? (THR_W+1)'(1) : {1'b0, thr_miss};
        hits_nxt = {1'b0, hits_q} + 1'b1;
        miss_nxt = {1'b0, miss_q} + 1'b1;
        load     = (state_q == ST_HUNT) && match;
        oof      = (state_q != ST_SYNC);
    end

    // State transitions and consecutive-frame counts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            hits_q  <= '0;
            miss_q  <= '0;
        end else begin
            case (state_q)
                ST_HUNT: begin
                    if (match) begin
                        hits_q  <= THR_W'(1);
                        miss_q  <= '0;
                        state_q <= (lock_eff <= (THR_W+1)'(1)) ? ST_SYNC : ST_PRESYNC;
                    end
                end
                ST_PRESYNC: begin
                    if (en && at_check) begin
                        if (match) begin
                            if (hits_nxt >= lock_eff) state_q <= ST_SYNC;
                            else hits_q <= hits_nxt[THR_W-1:0];
                        end else begin
                            state_q <= ST_HUNT;
                        end
                    end
                end
                ST_SYNC: begin
                    if (en && at_check) begin
                        if (match) begin
                            miss_q <= '0;
                        end else if (miss_nxt >= miss_eff) begin
                            miss_q  <= '0;
                            state_q <= ST_HUNT;
                        end else begin
                            miss_q <= miss_nxt[THR_W-1:0];
                        end
                    end
                end
                default: state_q <= ST_HUNT;
            endcase
        end
    end

    AST_LOCK_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oof) |-> $past(match)); // R3
    AST_OOF_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oof) |-> $past(en && at_check && !match)); // R5
endmodule

// File: rtl/fa_loss_timer.sv
// Loss-of-frame timer.
// It counts frame ends spent in the current alarm state and restarts on any change of oof.
// It sets lof after the set threshold while out of frame, and clears it after the clear threshold while in frame.
module fa_loss_timer #(
    parameter int THR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_end,
    input  logic             oof,
    input  logic [THR_W-1:0] thr_set,
    input  logic [THR_W-1:0] thr_clr,
    output logic             lof
);
    logic [THR_W-1:0] cnt_q;
    logic             oof_q;
    logic [THR_W:0]   set_eff;
    logic [THR_W:0]   clr_eff;
    logic [THR_W:0]   cnt_nxt;

    // Clamp thresholds and form the next count.
    always_comb begin
        set_eff = (thr_set == '0) ? (THR_W+1)'(1) : {1'b0, thr_set};
        clr_eff = (thr_clr == '0) ? (THR_W+1)'(1) : {1'b0, thr_clr};
        cnt_nxt = {1'b0, cnt_q} + 1'b1;
    end

    // Count frames in the present state and toggle lof at the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lof   <= 1'b0;
            cnt_q <= '0;
            oof_q <= 1'b1;
        end else begin
            oof_q <= oof;
            if (oof != oof_q) begin
                cnt_q <= '0;
            end else if (frame_end) begin
                if (oof && !lof) begin
                    if (cnt_nxt >= set_eff) begin
                        lof   <= 1'b1;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_nxt[THR_W-1:0];
                    end
                end else if (!oof && lof) begin
                    if (cnt_nxt >= clr_eff) begin
                        lof   <= 1'b0;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_nxt[THR_W-1:0];
                    end
                end
            end
        end
    end

    AST_LOF_SET_OOF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lof) |-> ($past(oof) && $past(frame_end))); // R6
    AST_LOF_CLR_INFRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lof) |-> (!$past(oof) && $past(frame_end))); // R7
endmodule

// File: rtl/frame_aligner.sv
// Frame aligner top.
// It finds the framing pattern in a byte-aligned receive stream, locks the timing counter to it and raises the out-of-frame and loss-of-frame alarms.
// Bytes leave one clock later tagged with their position.
// It assumes mode_stm1 changes only during reset.
module frame_aligner
    import fa_pkg::*;
#(
    parameter int COLS_HI = 270,
    parameter int COLS_LO = 90,
    parameter int THR_W   = 8,
    localparam int COL_W  = $clog2(COLS_HI),
    localparam int ROW_W  = $clog2(FA_ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic [7:0]       rx_byte,
    input  logic             mode_stm1,
    input  logic [THR_W-1:0] thr_lock,
    input  logic [THR_W-1:0] thr_miss,
    input  logic [THR_W-1:0] thr_lof_set,
    input  logic [THR_W-1:0] thr_lof_clr,
    output logic [7:0]       al_byte,
    output logic             al_valid,
    output logic [ROW_W-1:0] al_row,
    output logic [COL_W-1:0] al_col,
    output logic             frame_start,
    output logic             oof,
    output logic             lof
);
    logic             match;
    logic             load;
    logic             at_check;
    logic             frame_end;
    logic [ROW_W-1:0] cur_row;
    logic [COL_W-1:0] cur_col;

    fa_pattern_det #(.DW(8)) u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (rx_en),
        .mode_hi (mode_stm1),
        .din     (rx_byte),
        .match   (match)
    );

    fa_timing #(
        .COLS_HI (COLS_HI),
        .COLS_LO (COLS_LO),
        .ROW_W   (ROW_W),
        .COL_W   (COL_W)
    ) u_tim (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (rx_en),
        .mode_hi   (mode_stm1),
        .load      (load),
        .cur_row   (cur_row),
        .cur_col   (cur_col),
        .at_check  (at_check),
        .frame_end (frame_end)
    );

    fa_sync_fsm #(.THR_W(THR_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (rx_en),
        .match    (match),
        .at_check (at_check),
        .thr_lock (thr_lock),
        .thr_miss (thr_miss),
        .load     (load),
        .oof      (oof)
    );

    fa_loss_timer #(.THR_W(THR_W)) u_lof (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_end (frame_end),
        .oof       (oof),
        .thr_set   (thr_lof_set),
        .thr_clr   (thr_lof_clr),
        .lof       (lof)
    );

    // Register the aligned byte, its position and the frame-start marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            al_byte     <= '0;
            al_valid    <= 1'b0;
            al_row      <= '0;
            al_col      <= '0;
            frame_start <= 1'b0;
        end else begin
            al_valid    <= rx_en;
            frame_start <= rx_en && !oof && (cur_row == '0) && (cur_col == '0);
            if (rx_en) begin
                al_byte <= rx_byte;
                al_row  <= cur_row;
                al_col  <= cur_col;
            end
        end
    end
endmodule

// File: tb/frame_aligner_bench.sv
`timescale 1ns/1ps
module frame_aligner_bench;
    localparam int THR_W = 8;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             rx_en;
    logic [7:0]       rx_byte;
    logic             mode_stm1;
    logic [THR_W-1:0] thr_lock, thr_miss, thr_lof_set, thr_lof_clr;
    logic [7:0]       al_byte;
    logic             al_valid;
    logic [3:0]       al_row;
    logic [8:0]       al_col;
    logic             frame_start, oof, lof;

    always #2.5 clk = ~clk;

    frame_aligner u_frame_aligner (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_byte(rx_byte),
        .mode_stm1(mode_stm1), .thr_lock(thr_lock), .thr_miss(thr_miss),
        .thr_lof_set(thr_lof_set), .thr_lof_clr(thr_lof_clr),
        .al_byte(al_byte), .al_valid(al_valid), .al_row(al_row), .al_col(al_col),
        .frame_start(frame_start), .oof(oof), .lof(lof)
    );

    typedef struct {
        logic [7:0] d;
        bit         chk;
        int         row;
        int         col;
        bit         fs;
    } exp_t;

    exp_t q[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 0;
    int   cols    = 90;

    localparam int K_GOOD = 0, K_BAD = 1, K_DECOY = 2;

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Driver: present one byte, push its expected result.
    task automatic push_byte(input logic [7:0] b, input int idx, input bit chk, input bit fs);
        exp_t e;
        if (idx % 97 == 50) begin
            @(negedge clk);
            rx_en = 1'b0;
            rx_byte = 8'hF6;
        end
        @(negedge clk);
        rx_en   = 1'b1;
        rx_byte = b;
        e.d = b; e.chk = chk; e.row = idx / cols; e.col = idx % cols;
        e.fs = fs && (idx == 0);
        q.push_back(e);
    endtask

    task automatic send_frame(input int kind, input bit chk, input bit fs);
        for (int i = 0; i < 9 * cols; i++) begin
            logic [7:0] b;
            int dc;
            b  = 8'(i * 7 + 3);
            dc = 4 * cols + 50;
            if (mode_stm1) begin
                if (i < 3) b = 8'hF6;
                else if (i < 6) b = 8'h28;
            end else begin
                if (i == 0) b = 8'hF6;
                else if (i == 1) b = 8'h28;
            end
            if (kind == K_BAD && i < (mode_stm1 ? 6 : 2)) b = 8'h00;
            if (kind == K_DECOY) begin
                if (i == dc) b = 8'hF6;
                else if (i == dc + 1 || (mode_stm1 && i == dc + 2)) b = 8'h28;
            end
            push_byte(b, i, chk, fs);
        end
        @(negedge clk);
        rx_en = 1'b0;
    endtask

    task automatic do_reset(input bit hi, input int lock_n);
        rst_n = 1'b0; rx_en = 1'b0; rx_byte = 8'h00;
        mode_stm1 = hi; cols = hi ? 270 : 90;
        thr_lock = THR_W'(lock_n); thr_miss = 8'd3;
        thr_lof_set = 8'd4; thr_lof_clr = 8'd3;
        repeat (4) @(negedge clk);
        q.delete();
        check("R1 oof after reset", oof, 1);
        check("R1 lof after reset", lof, 0);
        check("R1 al_valid after reset", al_valid, 0);
        check("R1 frame_start after reset", frame_start, 0);
        rst_n = 1'b1;
    endtask

    // Monitor: pop and compare each byte the design emits.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && al_valid === 1'b1) begin
            if (q.size() == 0) begin
                check("R8 unexpected output byte", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check("R8 al_byte", al_byte, e.d);
                if (e.chk) begin
                    check("R4 al_row", al_row, e.row);
                    check("R4 al_col", al_col, e.col);
                    check("R9 frame_start", frame_start, e.fs);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R8 watchdog: actual 200000 cycles expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // 90-column mode, lock 2, miss 3, lof set 4, lof clear 3
        do_reset(1'b0, 2);
        send_frame(K_GOOD, 0, 0);
        check("R3 oof after first match", oof, 1);
        send_frame(K_GOOD, 1, 0);
        check("R3 oof after second match", oof, 0);
        check("R2 lof while locking", lof, 0);
        send_frame(K_GOOD, 1, 1);
        send_frame(K_DECOY, 1, 1);
        check("R4 decoy ignored in frame", oof, 0);
        // miss run below threshold, restarted by a good frame
        send_frame(K_BAD, 1, 1);
        send_frame(K_BAD, 1, 1);
        check("R5 two misses", oof, 0);
        send_frame(K_GOOD, 1, 1);
        send_frame(K_BAD, 1, 1);
        send_frame(K_BAD, 1, 1);
        check("R5 run restarted", oof, 0);
        send_frame(K_GOOD, 1, 1);
        // out of frame, then loss of frame
        send_frame(K_BAD, 1, 1);
        send_frame(K_BAD, 1, 1);
        send_frame(K_BAD, 0, 0);
        check("R5 third miss", oof, 1);
        send_frame(K_BAD, 1, 0);
        send_frame(K_BAD, 1, 0);
        check("R6 lof before threshold", lof, 0);
        send_frame(K_BAD, 1, 0);
        check("R6 lof at threshold", lof, 1);
        // recovery
        send_frame(K_GOOD, 1, 0);
        check("R3 oof after one match", oof, 1);
        send_frame(K_GOOD, 1, 0);
        check("R3 oof relocked", oof, 0);
        check("R7 lof held", lof, 1);
        send_frame(K_GOOD, 1, 1);
        check("R7 lof before clear", lof, 1);
        send_frame(K_GOOD, 1, 1);
        check("R7 lof cleared", lof, 0);
        // one-byte slip
        push_byte(8'h00, 0, 0, 0);
        send_frame(K_GOOD, 0, 0);
        send_frame(K_GOOD, 0, 0);
        check("R10 oof after two slipped frames", oof, 0);
        send_frame(K_GOOD, 0, 0);
        check("R10 oof after third slipped frame", oof, 1);
        send_frame(K_GOOD, 0, 0);
        check("R10 relocked", oof, 0);
        send_frame(K_GOOD, 1, 1);
        check("R10 lof untouched", lof, 0);
        repeat (3) @(negedge clk);
        // 270-column mode, lock threshold 0 acts as 1
        do_reset(1'b1, 0);
        send_frame(K_GOOD, 0, 0);
        check("R3 zero threshold locks in one frame", oof, 0);
        check("R2 lof in wide mode", lof, 0);
        send_frame(K_GOOD, 1, 1);
        send_frame(K_DECOY, 1, 1);
        check("R4 wide decoy ignored", oof, 0);
        repeat (3) @(negedge clk);
        check("R8 queue drained", q.size(), 0);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule